// File: doc/BRIEF.md
# Eight-Bit Bidirectional Port with Low-Power Pad Isolation

This block is an eight-bit general-purpose I/O port. It has a latch for output values and a per-bit direction mask. A small register bus writes both of them. The bus reads back either the direction mask or a mixed data view. For pins set as outputs, the data view shows the latched value. For pins set as inputs, it shows the pad value.

For each pad the block drives a value and a tri-state enable, and it receives the pad's input level. Two pins also carry a peripheral output. While that peripheral asserts its own enable, the peripheral takes over the pad.

The block watches the chip's power-mode code and an isolation-select bit. The deep modes are stop, timebase-timer and watch. When the chip is in one of them and the isolation bit is set, every port-driven output enable is forced off and the input path is clamped low. The direction mask does not change. The output latch has no reset, so its contents survive a reset. A reset returns the direction mask to all inputs.

Top module: `gpio_lp_port`

## Requirements
- R1: While rst_n is low at a clock edge, the direction mask clears to 0x00. After that edge every port-driven pad_oe bit is 0, and a read of the direction address returns 0x00.
- R2: The output latch is not cleared by reset. A value written before a reset appears again on pad_out once the direction bits are set to 1 after the reset.
- R3: When pads are not isolated, a direction bit of 1 sets that pin's pad_oe to 1 and its pad_out to the latched bit. A direction bit of 0 sets pad_oe to 0.
- R4: Isolation holds when iso_sel is 1 and pwr_mode is 2 (stop), 3 (timebase-timer) or 4 (watch). While it holds, every port-driven pad_oe bit is 0, whatever the direction mask contains.
- R5: While isolation holds, the sampled input of every pin is 0. A data-address read therefore returns 0 in all input-direction bit positions.
- R6: With iso_sel at 0, the port behaves exactly as in mode 0 in modes 2, 3 and 4.
- R7: Mode 1 (sleep) and the unused codes 5 to 7 behave as mode 0 (normal) for both values of iso_sel.
- R8: Pins 1 and 3 are peripheral pins. Peripheral index 0 drives pin 1 and index 1 drives pin 3. While periph_oe[k] is 1, pad_oe on that pin is 1 and pad_out equals periph_out[k], including while isolation holds. While periph_oe[k] is 0, the pin behaves as an ordinary port pin.
- R9: A read at address 0 returns, per bit, the latched value where the direction bit is 1 and the (possibly clamped) pad input where it is 0. A read at address 1 returns the direction mask.
- R10: When bus_we is 1 at a clock edge, bus_wdata is written to the output latch (bus_addr 0) or the direction mask (bus_addr 1). The new value is visible from that edge on, and the other register is left unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Single-cycle write strobe |
| bus_addr | input | 1 | 0 selects the data latch, 1 selects the direction mask |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data |
| pwr_mode | input | 3 | Power mode: 0 normal, 1 sleep, 2 stop, 3 timebase-timer, 4 watch |
| iso_sel | input | 1 | Isolation select for deep modes |
| periph_oe | input | 2 | Peripheral output enables for pins 1 and 3 |
| periph_out | input | 2 | Peripheral output values for pins 1 and 3 |
| pad_in | input | 8 | Pad input levels |
| pad_out | output | 8 | Pad output values |
| pad_oe | output | 8 | Pad output enables |

## Verification
The bench sweeps all eight mode codes against both isolation-select values, several direction masks, latch values and pad patterns. It compares every output with a model built from the requirements.

That sweep catches several kinds of fault:
- A decoder that leaves out timebase-timer or watch, or that takes sleep or an unused code as a deep mode, gives wrong pad_oe bits in those rows.
- Clamping inputs without isolation, or clamping the output-direction bits of a data read, shows up in bus_rdata.
- A design that lets isolation mask the peripheral enable, or that takes the wrong peripheral index for a pin, drives the wrong pad_oe or pad_out.
- A latch with a reset loses 0xA5 across the reset pulse.

// File: rtl/gpio_lp_pkg.sv
// Package: shared power-mode encoding and register addresses for the port.
// Assumes the mode code is three bits wide. Codes above 4 are unused and
// treated as normal operation.
package gpio_lp_pkg;
    typedef enum logic [2:0] {
        PM_RUN   = 3'd0,
        PM_SLEEP = 3'd1,
        PM_STOP  = 3'd2,
        PM_TBT   = 3'd3,
        PM_WATCH = 3'd4
    } pwr_mode_e;

    localparam logic ADDR_DATA = 1'b0;
    localparam logic ADDR_DIR  = 1'b1;
endpackage

// File: rtl/gpio_lp_lpctl.sv
// Module: isolation decoder. It raises iso_o when the select bit is set and
// the mode is one of the deep modes. The decode is purely combinational, so
// a mode change takes effect in the same cycle.
module gpio_lp_lpctl
    import gpio_lp_pkg::*;
(
    input  logic [2:0] pwr_mode_i,
    input  logic       iso_sel_i,
    output logic       iso_o
);
    logic deep_mode;

    // Flag the modes in which the select bit may isolate the pads.
    always_comb begin
        unique case (pwr_mode_i)
            PM_STOP, PM_TBT, PM_WATCH: deep_mode = 1'b1;
            default:                   deep_mode = 1'b0;
        endcase
    end

    // Combine the mode flag with the select bit.
    always_comb iso_o = deep_mode & iso_sel_i;
endmodule

// File: rtl/gpio_lp_regs.sv
// Module: the data latch and the direction mask, with the bus write path and
// the read multiplexer. The latch has no reset, so its contents are kept
// across a reset. The direction mask resets to all inputs. Reads are
// combinational.
module gpio_lp_regs
    import gpio_lp_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we_i,
    input  logic         addr_i,
    input  logic [W-1:0] wdata_i,
    input  logic [W-1:0] in_eff_i,
    output logic [W-1:0] rdata_o,
    output logic [W-1:0] data_o,
    output logic [W-1:0] dir_o
);
    logic [W-1:0] data_q;
    logic [W-1:0] dir_q;

    // Output latch: written from the bus only, never reset.
    always_ff @(posedge clk) begin
        if (we_i && addr_i == ADDR_DATA) data_q <= wdata_i;
    end

    // Direction mask: cleared to inputs on reset, otherwise written from the bus.
    always_ff @(posedge clk) begin
        if (!rst_n)                          dir_q <= '0;
        else if (we_i && addr_i == ADDR_DIR) dir_q <= wdata_i;
    end

    // Read view: the direction mask, or the latch on outputs merged with pad input on inputs.
    always_comb begin
        if (addr_i == ADDR_DIR) rdata_o = dir_q;
        else                    rdata_o = (dir_q & data_q) | (~dir_q & in_eff_i);
    end

    assign data_o = data_q;
    assign dir_o  = dir_q;

    // R10
    dir_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && addr_i == ADDR_DIR) |=> (dir_q == $past(wdata_i)));
    // R10
    data_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && addr_i == ADDR_DATA) |=> (data_q == $past(wdata_i)));
    // R1
    dir_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (dir_q == '0));
endmodule

// File: rtl/gpio_lp_padmux.sv
// Module: per-pin pad control. It gates the output enables and clamps the
// inputs while the pads are isolated. Two pins are peripheral pins: there the
// peripheral enable overrides the port. Isolation does not mask the
// peripheral enable, so the peripheral must release the pin before a deep mode.
module gpio_lp_padmux #(
    parameter int W     = 8,
    parameter int PIN_A = 1,
    parameter int PIN_B = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         iso_i,
    input  logic [W-1:0] data_i,
    input  logic [W-1:0] dir_i,
    input  logic [1:0]   periph_oe_i,
    input  logic [1:0]   periph_out_i,
    input  logic [W-1:0] pad_in_i,
    output logic [W-1:0] pad_out_o,
    output logic [W-1:0] pad_oe_o,
    output logic [W-1:0] in_eff_o
);
    logic [W-1:0] port_oe;

    // Port-driven enables: the direction mask, forced off while isolated.
    always_comb port_oe = iso_i ? '0 : dir_i;

    // Input path: pad levels, held at 0 while isolated.
    always_comb in_eff_o = iso_i ? '0 : pad_in_i;

    for (genvar i = 0; i < W; i++) begin : g_pin
        if (i == PIN_A || i == PIN_B) begin : g_periph
            localparam int K = (i == PIN_A) ? 0 : 1;
            assign pad_oe_o[i]  = periph_oe_i[K] | port_oe[i];
            assign pad_out_o[i] = periph_oe_i[K] ? periph_out_i[K] : data_i[i];

            // R8
            periph_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
                periph_oe_i[K] |-> (pad_oe_o[i] && pad_out_o[i] == periph_out_i[K]));
        end else begin : g_plain
            assign pad_oe_o[i]  = port_oe[i];
            assign pad_out_o[i] = data_i[i];
        end
    end

    // R4
    iso_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (iso_i && periph_oe_i == 2'b00) |-> (pad_oe_o == '0));
    // R5
    iso_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
        iso_i |-> (in_eff_o == '0));
    // R3
    dir_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!iso_i && periph_oe_i == 2'b00) |-> (pad_oe_o == dir_i));
endmodule

// File: rtl/gpio_lp_port.sv
// Module: top of the eight-bit port. It connects the isolation decoder, the
// register file and the pad multiplexer. It assumes the pads feed pad_in back
// from the pin, and that the bus holds its address for the whole cycle of a read.
module gpio_lp_port #(
    parameter int W     = 8,
    parameter int PIN_A = 1,
    parameter int PIN_B = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bus_we,
    input  logic         bus_addr,
    input  logic [W-1:0] bus_wdata,
    output logic [W-1:0] bus_rdata,
    input  logic [2:0]   pwr_mode,
    input  logic         iso_sel,
    input  logic [1:0]   periph_oe,
    input  logic [1:0]   periph_out,
    input  logic [W-1:0] pad_in,
    output logic [W-1:0] pad_out,
    output logic [W-1:0] pad_oe
);
    logic         iso;
    logic [W-1:0] data_q;
    logic [W-1:0] dir_q;
    logic [W-1:0] in_eff;

    gpio_lp_lpctl u_lpctl (
        .pwr_mode_i (pwr_mode),
        .iso_sel_i  (iso_sel),
        .iso_o      (iso)
    );

    gpio_lp_regs #(.W(W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .we_i     (bus_we),
        .addr_i   (bus_addr),
        .wdata_i  (bus_wdata),
        .in_eff_i (in_eff),
        .rdata_o  (bus_rdata),
        .data_o   (data_q),
        .dir_o    (dir_q)
    );

    gpio_lp_padmux #(.W(W), .PIN_A(PIN_A), .PIN_B(PIN_B)) u_padmux (
        .clk          (clk),
        .rst_n        (rst_n),
        .iso_i        (iso),
        .data_i       (data_q),
        .dir_i        (dir_q),
        .periph_oe_i  (periph_oe),
        .periph_out_i (periph_out),
        .pad_in_i     (pad_in),
        .pad_out_o    (pad_out),
        .pad_oe_o     (pad_oe),
        .in_eff_o     (in_eff)
    );

    // R7
    sleep_no_iso_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_mode == 3'd1 || pwr_mode == 3'd0 || pwr_mode > 3'd4) |-> !iso);
    // R6
    nosel_no_iso_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !iso_sel |-> !iso);
endmodule

// File: tb/gpio_lp_port_tb.sv
module gpio_lp_port_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_we = 1'b0;
    logic       bus_addr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [2:0] pwr_mode = '0;
    logic       iso_sel = 1'b0;
    logic [1:0] periph_oe = '0;
    logic [1:0] periph_out = '0;
    logic [7:0] pad_in = '0;
    logic [7:0] pad_out;
    logic [7:0] pad_oe;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    gpio_lp_port dut_i (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwr_mode(pwr_mode),
        .iso_sel(iso_sel), .periph_oe(periph_oe), .periph_out(periph_out),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic a, input logic [7:0] v);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = v;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    function automatic logic isolated(input logic [2:0] m, input logic s);
        return s && (m == 3'd2 || m == 3'd3 || m == 3'd4);
    endfunction

    logic [7:0] dirs [4] = '{8'h00, 8'hFF, 8'h5A, 8'hC3};
    logic [7:0] datas [3] = '{8'h00, 8'hFF, 8'h96};
    logic [7:0] pads [3] = '{8'hFF, 8'h3C, 8'h81};

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        #1;
        check("R1 oe", pad_oe, 8'h00);
        bus_addr = 1'b1; #0.1;
        check("R1 dir", bus_rdata, 8'h00);
        @(negedge clk); rst_n = 1'b1;

        // R10: write data then dir, each leaves the other unchanged
        bus_write(1'b0, 8'hA5);
        bus_addr = 1'b1; #1;
        check("R10 dir untouched", bus_rdata, 8'h00);
        bus_write(1'b1, 8'hFF);
        #1;
        check("R10 dir", pad_oe, 8'hFF);
        check("R10 data", pad_out, 8'hA5);

        // R2: latch survives reset, R1 dir cleared
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1; #1;
        check("R1 oe after reset", pad_oe, 8'h00);
        bus_write(1'b1, 8'hFF); #1;
        check("R2 latch kept", pad_out, 8'hA5);

        // Sweep: R3 R4 R5 R6 R7 R9
        for (int di = 0; di < 4; di++) begin
            for (int ti = 0; ti < 3; ti++) begin
                bus_write(1'b0, datas[ti]);
                bus_write(1'b1, dirs[di]);
                for (int m = 0; m < 8; m++) begin
                    for (int s = 0; s < 2; s++) begin
                        for (int p = 0; p < 3; p++) begin
                            logic iso;
                            logic [7:0] eoe, erd;
                            @(negedge clk);
                            pwr_mode = 3'(m); iso_sel = s[0]; pad_in = pads[p];
                            bus_addr = 1'b0;
                            #1;
                            iso = isolated(3'(m), s[0]);
                            eoe = iso ? 8'h00 : dirs[di];
                            erd = (dirs[di] & datas[ti]) | (~dirs[di] & (iso ? 8'h00 : pads[p]));
                            check(iso ? "R4 oe" : "R3 R6 R7 oe", pad_oe, eoe);
                            check("R3 out", pad_out, datas[ti]);
                            check(iso ? "R5 read" : "R9 read", bus_rdata, erd);
                            bus_addr = 1'b1; #0.5;
                            check("R9 dir read", bus_rdata, dirs[di]);
                        end
                    end
                end
            end
        end

        // R8: peripheral pins override, also while isolated
        bus_write(1'b0, 8'h00);
        bus_write(1'b1, 8'h00);
        for (int m = 0; m < 8; m++) begin
            for (int s = 0; s < 2; s++) begin
                for (int e = 0; e < 4; e++) begin
                    for (int v = 0; v < 4; v++) begin
                        logic [7:0] eoe, eout;
                        @(negedge clk);
                        pwr_mode = 3'(m); iso_sel = s[0];
                        periph_oe = 2'(e); periph_out = 2'(v);
                        #1;
                        eoe = {4'b0, e[1], 1'b0, e[0], 1'b0};
                        eout = {4'b0, e[1] & v[1], 1'b0, e[0] & v[0], 1'b0};
                        check("R8 oe", pad_oe, eoe);
                        check("R8 out", pad_out, eout);
                    end
                end
            end
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule